// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Responder

This block is the addressing layer of a slave on a single-wire open-drain bus. A bit-level front end, outside this block, turns line timing into three one-cycle events: a bus reset, a bit written by the master, and a read slot opened by the master. The block decodes the 8-bit ROM command that follows every bus reset and then runs that command against a 64-bit device identity. The identity is supplied on an input port. Its low byte holds the family code 28h, the next 48 bits hold the serial number, and the top byte holds a CRC of the lower 56 bits. The block does not check these fields.

The supported commands are read, match, skip, search, and alarm-qualified search. For every read slot the block presents the bit to return, where 1 means the line is released. It raises `selected_o` when the device has been addressed, which lets a function-command layer act. A device that is not addressed, or that drops out of a search, stays silent until the next bus reset.

Top module: `ow_rom_responder`

## Requirements
- R1: After `rst_ni` is asserted, `selected_o` is 0 and `rd_bit_o` is 1. All bit events and read slots are then ignored until the first `bus_reset_i`.
- R2: A `bus_reset_i` in any state returns the block to command reception and clears `selected_o` on the next cycle. A reset in the same cycle as a bit event or a read slot takes precedence, and that event is discarded.
- R3: The command is taken from 8 written bits, least significant bit first. The opcodes are read = 33h, match = 55h, skip = CCh, search = F0h and alarm search = ECh. Skip sets `selected_o` in the cycle after the eighth bit.
- R4: Read returns the 64 identity bits on `rd_bit_o`, bit 0 first. Each bit is presented before its read slot and advances one cycle after that slot. After the 64th slot `selected_o` is set.
- R5: Match compares 64 written bits, bit 0 first, against the identity. If all 64 are equal, `selected_o` is set after the last bit. On the first unequal bit the block goes silent until the next bus reset.
- R6: Search handles each identity bit in three steps: a read slot returns the bit, a second read slot returns its complement, and a written bit is then compared with the identity bit. If they differ, the device drops out. After 64 bits the device goes silent and is never selected.
- R7: Alarm search behaves as search when `alarm_i` is 1 in the cycle of the eighth command bit. Otherwise the device goes silent at once.
- R8: An unknown opcode leaves the device silent until the next bus reset. In that state read slots return 1, written bits have no effect, and `selected_o` stays 0.
- R9: Events of the kind a state does not expect are ignored. These are written bits during read and during the two read steps of search, and read slots during command reception and match. `rd_bit_o` is 1 whenever the block is not transmitting.
- R10: While the device is selected, `rd_bit_o` is 1, and bit events and read slots leave `selected_o` set until a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | One-cycle pulse: the front end has detected a bus reset |
| bit_valid_i | input | 1 | One-cycle pulse: the master has written a bit |
| bit_i | input | 1 | Value of the written bit |
| rd_slot_i | input | 1 | One-cycle pulse: the master has opened a read slot |
| alarm_i | input | 1 | Alarm flag from the sensor side |
| id_i | input | 64 | Device identity (family code, serial number, CRC) |
| rd_bit_o | output | 1 | Bit to return in the next read slot (1 = release the line) |
| selected_o | output | 1 | Device is addressed; the function layer may act |

## Verification
A bus reset can arrive in the same cycle as a written bit or a read slot. It can also land partway through a match, a read or a search. The bench drives the reset together with a written bit that would otherwise complete or break a match, and together with a read slot partway through a read. It then checks on every clock that the model, which discards the coincident event, agrees with `selected_o` and `rd_bit_o`. The bench also sends out-of-place events, such as written bits during read steps and read slots during command reception, and checks that the presented bit does not advance.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;
  localparam logic [7:0] OP_READ   = 8'h33;
  localparam logic [7:0] OP_MATCH  = 8'h55;
  localparam logic [7:0] OP_SKIP   = 8'hCC;
  localparam logic [7:0] OP_SEARCH = 8'hF0;
  localparam logic [7:0] OP_ALARM  = 8'hEC;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_READ, ST_MATCH, ST_SRCH, ST_SEL
  } rom_state_e;

  typedef enum logic [1:0] {
    PH_ID, PH_CMPL, PH_DIR
  } srch_phase_e;

  function automatic rom_state_e decode_op(input logic [7:0] op, input logic alarm);
    case (op)
      OP_READ:   decode_op = ST_READ;
      OP_MATCH:  decode_op = ST_MATCH;
      OP_SKIP:   decode_op = ST_SEL;
      OP_SEARCH: decode_op = ST_SRCH;
      OP_ALARM:  decode_op = alarm ? ST_SRCH : ST_IDLE;
      default:   decode_op = ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/ow_bit_ctr.sv
module ow_bit_ctr #(
  parameter int N  = 64,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == W'(N - 1));
  assign cnt_o  = cnt_q;

  AST_CTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R2
endmodule

// File: rtl/ow_cmd_shift.sv
module ow_cmd_shift #(
  parameter int CMD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [CMD_W-1:0] peek_o,
  output logic             last_o
);
  logic [CMD_W-1:0] sh_q;
  logic [$clog2(CMD_W)-1:0] cnt;

  ow_bit_ctr #(.N(CMD_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i, .inc_i(shift_i), .cnt_o(cnt), .last_o
  );

  // LSB first: new bit enters at the top
  assign peek_o = {bit_i, sh_q[CMD_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (clr_i)   sh_q <= '0;
    else if (shift_i) sh_q <= peek_o;
  end

  AST_CMD_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !clr_i |=> sh_q[CMD_W-1] == $past(bit_i)); // R3
endmodule

// File: rtl/ow_rom_responder.sv
module ow_rom_responder
  import ow_rom_pkg::*;
#(
  parameter int ID_W  = 64,
  parameter int CMD_W = 8,
  localparam int IW   = $clog2(ID_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_reset_i,
  input  logic            bit_valid_i,
  input  logic            bit_i,
  input  logic            rd_slot_i,
  input  logic            alarm_i,
  input  logic [ID_W-1:0] id_i,
  output logic            rd_bit_o,
  output logic            selected_o
);
  rom_state_e  st_q, st_d;
  srch_phase_e ph_q, ph_d;
  logic wr_ev, rd_ev;
  logic cmd_clr, cmd_shift, cmd_last;
  logic idx_clr, idx_inc, idx_last;
  logic [CMD_W-1:0] op_peek;
  logic [IW-1:0]    idx;
  logic             id_bit;

  // bus reset wins over coincident bit events
  assign wr_ev  = bit_valid_i & ~bus_reset_i;
  assign rd_ev  = rd_slot_i & ~bus_reset_i;
  assign id_bit = id_i[idx];

  ow_cmd_shift #(.CMD_W(CMD_W)) u_cmd (
    .clk_i, .rst_ni, .clr_i(cmd_clr), .shift_i(cmd_shift), .bit_i,
    .peek_o(op_peek), .last_o(cmd_last)
  );

  ow_bit_ctr #(.N(ID_W)) u_idx (
    .clk_i, .rst_ni, .clr_i(idx_clr), .inc_i(idx_inc), .cnt_o(idx), .last_o(idx_last)
  );

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    cmd_clr = 1'b0;
    cmd_shift = 1'b0;
    idx_clr = 1'b0;
    idx_inc = 1'b0;
    if (bus_reset_i) begin
      st_d = ST_CMD;
      ph_d = PH_ID;
      cmd_clr = 1'b1;
      idx_clr = 1'b1;
    end else begin
      case (st_q)
        ST_CMD: if (wr_ev) begin
          cmd_shift = 1'b1;
          if (cmd_last) begin
            st_d = decode_op(op_peek, alarm_i);
            ph_d = PH_ID;
            idx_clr = 1'b1;
          end
        end
        ST_READ: if (rd_ev) begin
          idx_inc = 1'b1;
          if (idx_last) st_d = ST_SEL;
        end
        ST_MATCH: if (wr_ev) begin
          if (bit_i != id_bit) st_d = ST_IDLE;
          else begin
            idx_inc = 1'b1;
            if (idx_last) st_d = ST_SEL;
          end
        end
        ST_SRCH: begin
          case (ph_q)
            PH_ID:   if (rd_ev) ph_d = PH_CMPL;
            PH_CMPL: if (rd_ev) ph_d = PH_DIR;
            default: if (wr_ev) begin
              if (bit_i != id_bit) st_d = ST_IDLE;
              else begin
                idx_inc = 1'b1;
                ph_d = PH_ID;
                if (idx_last) st_d = ST_IDLE;
              end
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      ph_q <= PH_ID;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  always_comb begin
    rd_bit_o = 1'b1;
    if (st_q == ST_READ) rd_bit_o = id_bit;
    else if (st_q == ST_SRCH && ph_q == PH_ID)   rd_bit_o = id_bit;
    else if (st_q == ST_SRCH && ph_q == PH_CMPL) rd_bit_o = ~id_bit;
  end

  assign selected_o = (st_q == ST_SEL);

  AST_RESET_DESELECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> !selected_o && st_q == ST_CMD); // R2
  AST_SILENT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_IDLE && !bus_reset_i |=> st_q == ST_IDLE && rd_bit_o); // R8
  AST_SRCH_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_SRCH && ph_q == PH_ID && rd_ev |=>
      (!$stable(id_i) || rd_bit_o != $past(rd_bit_o))); // R6
  AST_MATCH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_MATCH && wr_ev && bit_i != id_bit |=> !selected_o && rd_bit_o); // R5
  AST_SEL_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(selected_o) |-> $past(st_q) inside {ST_CMD, ST_READ, ST_MATCH}); // R3
  AST_SEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    selected_o && !bus_reset_i |=> selected_o); // R10
endmodule

// File: tb/ow_rom_responder_tb.sv
module ow_rom_responder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ID = 64'hA7_3C5E91D2B6_04_28;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_reset_i = 1'b0, bit_valid_i = 1'b0, bit_i = 1'b0, rd_slot_i = 1'b0, alarm_i = 1'b0;
  logic [63:0] id_i = ID;
  logic rd_bit_o, selected_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ow_rom_responder dut_i (
    .clk_i, .rst_ni, .bus_reset_i, .bit_valid_i, .bit_i, .rd_slot_i,
    .alarm_i, .id_i, .rd_bit_o, .selected_o
  );

  // behavioural model: 0 silent, 1 cmd, 2 read, 3 match, 4 search, 5 selected
  int m_st = 0, m_idx = 0, m_step = 0;
  bit m_cmd[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always @(posedge clk_i) if (rst_ni) begin
    if (bus_reset_i) begin
      m_st = 1; m_idx = 0; m_step = 0; m_cmd.delete();
    end else begin
      case (m_st)
        1: if (bit_valid_i) begin
          m_cmd.push_back(bit_i);
          if (m_cmd.size() == 8) begin
            logic [7:0] op;
            for (int k = 0; k < 8; k++) op[k] = m_cmd[k];
            m_idx = 0; m_step = 0;
            if (op == 8'h33) m_st = 2;
            else if (op == 8'h55) m_st = 3;
            else if (op == 8'hCC) m_st = 5;
            else if (op == 8'hF0) m_st = 4;
            else if (op == 8'hEC) m_st = alarm_i ? 4 : 0;
            else m_st = 0;
          end
        end
        2: if (rd_slot_i) begin m_idx++; if (m_idx == 64) m_st = 5; end
        3: if (bit_valid_i) begin
          if (bit_i != ID[m_idx]) m_st = 0;
          else begin m_idx++; if (m_idx == 64) m_st = 5; end
        end
        4: if (m_step < 2) begin
          if (rd_slot_i) m_step++;
        end else if (bit_valid_i) begin
          if (bit_i != ID[m_idx]) m_st = 0;
          else begin m_step = 0; m_idx++; if (m_idx == 64) m_st = 0; end
        end
        default: ;
      endcase
    end
  end

  function automatic logic exp_rd();
    if (m_st == 2) return ID[m_idx];
    if (m_st == 4 && m_step == 0) return ID[m_idx];
    if (m_st == 4 && m_step == 1) return ~ID[m_idx];
    return 1'b1;
  endfunction

  task automatic compare();
    logic es, er;
    es = (m_st == 5);
    er = exp_rd();
    n_vec++;
    if (selected_o !== es || rd_bit_o !== er) begin
      n_bad++;
      $display("FAIL %s t=%0t selected act %b exp %b, rd_bit act %b exp %b",
               cur_req, $time, selected_o, es, rd_bit_o, er);
    end
  endtask

  // one clock: check outputs, then drive events for the next edge
  task automatic ev(input logic r, input logic v, input logic b, input logic s);
    @(negedge clk_i);
    compare();
    bus_reset_i = r; bit_valid_i = v; bit_i = b; rd_slot_i = s;
  endtask

  task automatic gap(); ev(0, 0, 0, 0); endtask
  task automatic bus_rst(); ev(1, 0, 0, 0); endtask
  task automatic wr(input logic b); ev(0, 1, b, 0); endtask
  task automatic rd(); ev(0, 0, 0, 1); endtask
  task automatic send_op(input logic [7:0] op);
    for (int k = 0; k < 8; k++) wr(op[k]);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    cur_req = "R1"; compare();
    rst_ni = 1'b1;
    send_op(8'hCC); rd(); rd(); gap(); gap();

    cur_req = "R3"; bus_rst(); send_op(8'hCC); gap();
    cur_req = "R10"; rd(); wr(0); wr(1); rd(); send_op(8'h55); gap();
    cur_req = "R2"; bus_rst(); gap(); gap();

    cur_req = "R4"; bus_rst(); send_op(8'h33);
    for (int i = 0; i < 64; i++) begin rd(); if (i % 5 == 0) begin cur_req = "R9"; wr(~ID[i]); cur_req = "R4"; end end
    gap(); rd(); gap();

    cur_req = "R9"; bus_rst(); rd(); rd(); send_op(8'h55); rd(); rd();
    cur_req = "R5"; for (int i = 0; i < 64; i++) wr(ID[i]);
    gap();
    bus_rst(); send_op(8'h55);
    for (int i = 0; i < 37; i++) wr(ID[i]);
    wr(~ID[37]); for (int i = 38; i < 64; i++) wr(ID[i]);
    rd(); gap();

    cur_req = "R2"; bus_rst(); send_op(8'h55);
    for (int i = 0; i < 20; i++) wr(ID[i]);
    ev(1, 1, ~ID[20], 0); send_op(8'h33);
    for (int i = 0; i < 10; i++) rd();
    ev(1, 0, 0, 1); gap(); send_op(8'hCC); gap();

    cur_req = "R6"; bus_rst(); send_op(8'hF0);
    for (int i = 0; i < 64; i++) begin rd(); cur_req = "R9"; wr(ID[i]); cur_req = "R6"; rd(); wr(ID[i]); end
    gap(); rd(); wr(1); gap();
    bus_rst(); send_op(8'hF0);
    for (int i = 0; i < 5; i++) begin rd(); rd(); wr(ID[i]); end
    rd(); rd(); wr(~ID[5]); rd(); rd(); gap();

    cur_req = "R7"; alarm_i = 1'b1; bus_rst(); send_op(8'hEC);
    for (int i = 0; i < 8; i++) begin rd(); rd(); wr(ID[i]); end
    alarm_i = 1'b0; for (int i = 8; i < 12; i++) begin rd(); rd(); wr(ID[i]); end
    bus_rst(); send_op(8'hEC); rd(); rd(); wr(ID[0]); gap();

    cur_req = "R8"; bus_rst(); send_op(8'hA5); rd(); rd(); send_op(8'hCC); rd(); gap();
    cur_req = "R2"; bus_rst(); send_op(8'hCC); gap(); gap();

    gap();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired, last %s, act running exp finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule